// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Stage

This block is the issue-check stage of a two-way in-order superscalar pipeline. Each cycle it may take one 64-bit fetch packet made of two 32-bit instructions. The upper half (the left slot) is the older instruction and is meant for the integer side. The lower half (the right slot) is meant for a floating-point arithmetic operation. The block holds the packet and decides whether none, one or both instructions issue this cycle. Issued instructions leave through registered outputs, one cycle after the decision.

The decision looks at the two operation kinds and the six register specifiers. It also looks at the destination of any load issued in the previous cycle. A load's result cannot be used by an FP operation paired with it, or by either instruction of the next issue cycle. A wrongly slotted pair is split. The left instruction goes alone and the right one follows a cycle later. A load-use hazard freezes the whole packet for one cycle. While anything of the packet is still waiting, the block asserts a stall towards fetch and ignores new packets.

Each instruction word carries the following fields:

- Kind: bits [31:29].
- Destination register: bits [25:21].
- First source register: bits [20:16].
- Second source register: bits [15:11].

Top module: `dual_issue_pair`

## Requirements
- R1: Kind codes are 0 integer ALU (reads int ra, int rb; writes int rd), 1 integer load (reads int ra; writes int rd), 2 integer store (reads int ra, int rb), 3 FP load (reads int ra; writes fp rd), 4 FP store (reads int ra, fp rb), 5 FP arithmetic (reads fp ra, fp rb; writes fp rd), 6 branch (reads int ra), 7 no-op. Both slots issue in the same cycle only if the left kind is not 5 and the right kind is 5.
- R2: The right instruction of a fresh packet never issues in a cycle in which the left one does not issue.
- R3: A pair that fails R1 issues the left instruction alone, then the right instruction alone in the next cycle, whatever its kind.
- R4: If the left instruction writes a register of the register file that the right instruction reads, the two do not pair, and the right instruction issues afterwards.
- R5: If both instructions write the same register of the same file, the two do not pair.
- R6: An instruction that reads, in the matching file, the destination of a load issued in the previous cycle does not issue that cycle. Its whole packet is held for one cycle. A load to the other register file causes no hold.
- R7: After reset nothing is issued, no packet is held and the stall output is low.
- R8: An instruction issued by the decision made in cycle t appears on the issue outputs, with its full word, after the clock edge that ends cycle t.
- R9: The stall output is high exactly when an instruction of the held packet stays unissued at the end of the current cycle. A packet offered while it is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetch packet is offered |
| in_pkt | input | 64 | Fetch packet: [63:32] left slot, [31:0] right slot |
| fetch_stall | output | 1 | Held packet not finished; offered packet is not taken |
| iss_l_v | output | 1 | Left-slot instruction issued |
| iss_l_w | output | 32 | Issued left-slot word |
| iss_r_v | output | 1 | Right-slot instruction issued |
| iss_r_w | output | 32 | Issued right-slot word |

## Verification
The first sweep sends every pairing of the eight kinds in isolated packets, each pairing under three register layouts: fully disjoint registers, the left destination read by the right slot, and a shared destination. This separates correct pairing from split issue, and a same-packet hazard from a harmless name match in the other file. The second sweep sends back-to-back packets, where an integer or FP load is followed by a consumer of every kind. This separates the one-cycle load hold from the file-mismatch case. A final case offers a packet while the stall is high and confirms that only the original held word issues.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  localparam int KIND_W = 3;
  localparam int REG_W  = 5;

  typedef enum logic [KIND_W-1:0] {
    K_ALU    = 3'd0,
    K_ILOAD  = 3'd1,
    K_ISTORE = 3'd2,
    K_FLOAD  = 3'd3,
    K_FSTORE = 3'd4,
    K_FPOP   = 3'd5,
    K_BRANCH = 3'd6,
    K_NOP    = 3'd7
  } op_kind_e;

  typedef struct packed {
    logic             fp_pipe;
    logic             is_load;
    logic             wr_en;
    logic             wr_fp;
    logic [REG_W-1:0] rd;
    logic             a_en;
    logic             a_fp;
    logic [REG_W-1:0] ra;
    logic             b_en;
    logic             b_fp;
    logic [REG_W-1:0] rb;
  } slot_info_t;
endpackage

// File: rtl/dual_issue_decode.sv
module dual_issue_decode
  import dual_issue_pkg::*;
(
  input  op_kind_e         kind,
  input  logic [REG_W-1:0] f_rd,
  input  logic [REG_W-1:0] f_ra,
  input  logic [REG_W-1:0] f_rb,
  output slot_info_t       info
);
  always_comb begin
    info    = '0;
    info.rd = f_rd;
    info.ra = f_ra;
    info.rb = f_rb;
    case (kind)
      K_ALU: begin
        info.wr_en = 1'b1;
        info.a_en  = 1'b1;
        info.b_en  = 1'b1;
      end
      K_ILOAD: begin
        info.is_load = 1'b1;
        info.wr_en   = 1'b1;
        info.a_en    = 1'b1;
      end
      K_ISTORE: begin
        info.a_en = 1'b1;
        info.b_en = 1'b1;
      end
      K_FLOAD: begin
        info.is_load = 1'b1;
        info.wr_en   = 1'b1;
        info.wr_fp   = 1'b1;
        info.a_en    = 1'b1;
      end
      K_FSTORE: begin
        info.a_en = 1'b1;
        info.b_en = 1'b1;
        info.b_fp = 1'b1;
      end
      K_FPOP: begin
        info.fp_pipe = 1'b1;
        info.wr_en   = 1'b1;
        info.wr_fp   = 1'b1;
        info.a_en    = 1'b1;
        info.a_fp    = 1'b1;
        info.b_en    = 1'b1;
        info.b_fp    = 1'b1;
      end
      K_BRANCH: info.a_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_issue_arbiter.sv
module dual_issue_arbiter
  import dual_issue_pkg::*;
(
  input  slot_info_t       li,
  input  slot_info_t       ri,
  input  logic             lv,
  input  logic             rv,
  input  logic             ld_v,
  input  logic             ld_fp,
  input  logic [REG_W-1:0] ld_rd,
  output logic             go_l,
  output logic             go_r
);
  function automatic logic reads_reg(slot_info_t s, logic fp, logic [REG_W-1:0] r);
    return (s.a_en && s.a_fp == fp && s.ra == r) ||
           (s.b_en && s.b_fp == fp && s.rb == r);
  endfunction

  logic l_wait, r_wait, load_hold, raw_pair, waw_pair, can_pair;

  always_comb begin
    l_wait    = lv && ld_v && reads_reg(li, ld_fp, ld_rd);
    r_wait    = rv && ld_v && reads_reg(ri, ld_fp, ld_rd);
    load_hold = l_wait || r_wait;
    raw_pair  = li.wr_en && reads_reg(ri, li.wr_fp, li.rd);
    waw_pair  = li.wr_en && ri.wr_en && (li.wr_fp == ri.wr_fp) && (li.rd == ri.rd);
    can_pair  = !li.fp_pipe && ri.fp_pipe && !raw_pair && !waw_pair;
    go_l = 1'b0;
    go_r = 1'b0;
    if (!load_hold) begin
      if (lv) begin
        go_l = 1'b1;
        go_r = rv && can_pair;
      end else begin
        go_r = rv;
      end
    end
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dual_issue_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int KIND_LSB = 29,
  parameter int RD_LSB   = 21,
  parameter int RA_LSB   = 16,
  parameter int RB_LSB   = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2*INSTR_W-1:0] in_pkt,
  output logic                 fetch_stall,
  output logic                 iss_l_v,
  output logic [INSTR_W-1:0]   iss_l_w,
  output logic                 iss_r_v,
  output logic [INSTR_W-1:0]   iss_r_w
);
  localparam int SLOTS = 2;
  localparam int PKT_W = SLOTS * INSTR_W;

  logic [INSTR_W-1:0] cur_w [SLOTS];
  logic [SLOTS-1:0]   cur_v;
  slot_info_t         info  [SLOTS];
  logic [SLOTS-1:0]   go;
  logic               ld_v_q, ld_fp_q;
  logic [REG_W-1:0]   ld_rd_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    dual_issue_decode u_dec (
      .kind (op_kind_e'(cur_w[g][KIND_LSB +: KIND_W])),
      .f_rd (cur_w[g][RD_LSB +: REG_W]),
      .f_ra (cur_w[g][RA_LSB +: REG_W]),
      .f_rb (cur_w[g][RB_LSB +: REG_W]),
      .info (info[g])
    );
  end

  dual_issue_arbiter u_arb (
    .li    (info[0]),
    .ri    (info[1]),
    .lv    (cur_v[0]),
    .rv    (cur_v[1]),
    .ld_v  (ld_v_q),
    .ld_fp (ld_fp_q),
    .ld_rd (ld_rd_q),
    .go_l  (go[0]),
    .go_r  (go[1])
  );

  assign fetch_stall = |(cur_v & ~go);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v <= '0;
      for (int i = 0; i < SLOTS; i++) cur_w[i] <= '0;
    end else if (!fetch_stall) begin
      cur_v <= {SLOTS{in_valid}};
      if (in_valid) begin
        cur_w[0] <= in_pkt[PKT_W-1 -: INSTR_W];
        cur_w[1] <= in_pkt[INSTR_W-1:0];
      end
    end else begin
      cur_v <= cur_v & ~go;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_v_q  <= 1'b0;
      ld_fp_q <= 1'b0;
      ld_rd_q <= '0;
    end else if (go[0] && info[0].is_load) begin
      ld_v_q  <= 1'b1;
      ld_fp_q <= info[0].wr_fp;
      ld_rd_q <= info[0].rd;
    end else if (go[1] && info[1].is_load) begin
      ld_v_q  <= 1'b1;
      ld_fp_q <= info[1].wr_fp;
      ld_rd_q <= info[1].rd;
    end else begin
      ld_v_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_l_v <= 1'b0;
      iss_r_v <= 1'b0;
      iss_l_w <= '0;
      iss_r_w <= '0;
    end else begin
      iss_l_v <= go[0];
      iss_r_v <= go[1];
      iss_l_w <= cur_w[0];
      iss_r_w <= cur_w[1];
    end
  end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
  import dual_issue_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        fetch_stall,
  input logic        iss_l_v,
  input logic [31:0] iss_l_w,
  input logic        iss_r_v,
  input logic [31:0] iss_r_w,
  input logic [31:0] held_l,
  input logic [31:0] held_r
);
  slot_info_t il, ir;
  logic pl_v, pl_fp;
  logic [REG_W-1:0] pl_rd;

  dual_issue_decode u_dl (.kind(op_kind_e'(iss_l_w[31:29])), .f_rd(iss_l_w[25:21]),
                          .f_ra(iss_l_w[20:16]), .f_rb(iss_l_w[15:11]), .info(il));
  dual_issue_decode u_dr (.kind(op_kind_e'(iss_r_w[31:29])), .f_rd(iss_r_w[25:21]),
                          .f_ra(iss_r_w[20:16]), .f_rb(iss_r_w[15:11]), .info(ir));

  function automatic logic uses(slot_info_t s, logic fp, logic [REG_W-1:0] r);
    return (s.a_en && s.a_fp == fp && s.ra == r) || (s.b_en && s.b_fp == fp && s.rb == r);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_v <= 1'b0; pl_fp <= 1'b0; pl_rd <= '0;
    end else begin
      pl_v  <= (iss_l_v && il.is_load) || (iss_r_v && ir.is_load);
      pl_fp <= (iss_l_v && il.is_load) ? il.wr_fp : ir.wr_fp;
      pl_rd <= (iss_l_v && il.is_load) ? il.rd : ir.rd;
    end
  end

  assert_pair_kinds_R1: assert property (@(posedge clk) disable iff (rst)
    (iss_l_v && iss_r_v) |-> (iss_l_w[31:29] != K_FPOP && iss_r_w[31:29] == K_FPOP));

  assert_no_pair_raw_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_l_v && iss_r_v && il.wr_en) |-> !uses(ir, il.wr_fp, il.rd));

  assert_no_pair_waw_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_l_v && iss_r_v && il.wr_en && ir.wr_en) |-> (il.wr_fp != ir.wr_fp || il.rd != ir.rd));

  assert_load_delay_R6: assert property (@(posedge clk) disable iff (rst)
    pl_v |-> !((iss_l_v && uses(il, pl_fp, pl_rd)) || (iss_r_v && uses(ir, pl_fp, pl_rd))));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    $past(rst) |-> (!iss_l_v && !iss_r_v && !fetch_stall));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |=> ($stable(held_l) && $stable(held_r)));
endmodule

bind dual_issue_pair dual_issue_pair_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_stall (fetch_stall),
  .iss_l_v     (iss_l_v),
  .iss_l_w     (iss_l_w),
  .iss_r_v     (iss_r_v),
  .iss_r_w     (iss_r_w),
  .held_l      (cur_w[0]),
  .held_r      (cur_w[1])
);

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K_ALU = 0, K_ILD = 1, K_FLD = 3, K_FPA = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_pkt = '0;
  logic        fetch_stall, iss_l_v, iss_r_v;
  logic [31:0] iss_l_w, iss_r_w;
  int n_chk = 0, n_fail = 0;

  dual_issue_pair u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
    .fetch_stall(fetch_stall), .iss_l_v(iss_l_v), .iss_l_w(iss_l_w),
    .iss_r_v(iss_r_v), .iss_r_w(iss_r_w));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(int k, int d, int a, int b);
    return {k[2:0], 3'b000, d[4:0], a[4:0], b[4:0], 11'b0};
  endfunction

  // R1 read table: does kind k read register r of the given file?
  function automatic bit rd_of(int k, bit fp, int r, int a, int b);
    case (k)
      0, 2:    return !fp && (a == r || b == r);
      1, 3, 6: return !fp && a == r;
      4:       return (!fp && a == r) || (fp && b == r);
      5:       return fp && (a == r || b == r);
      default: return 0;
    endcase
  endfunction

  function automatic bit wr_of(int k, output bit fp);
    fp = (k == 3 || k == 5);
    return (k == 0 || k == 1 || k == 3 || k == 5);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic watch_seq(string req, bit el[4], bit er[4], logic [31:0] wl, logic [31:0] wr);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk({req, " R8 left valid"}, iss_l_v, el[k]);
      chk({req, " R8 right valid"}, iss_r_v, er[k]);
      if (el[k]) chk({req, " R8 left word"}, iss_l_w, wl);
      if (er[k]) chk({req, " R8 right word"}, iss_r_w, wr);
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R7 stall after reset", fetch_stall, 0);
    chk("R7 left after reset", iss_l_v, 0);
    chk("R7 right after reset", iss_r_v, 0);

    // Sweep 1: isolated packets, all kind pairs, three register layouts (R1-R5 tags below)
    for (int lk = 0; lk < 8; lk++)
      for (int rk = 0; rk < 8; rk++)
        for (int cfg = 0; cfg < 3; cfg++) begin
          int ld_ = 7, la = 2, lb = 3, rd_, ra, rb;
          bit pair, lwfp, rwfp, lw, rw, raw, waw, hz;
          bit el[4], er[4];
          logic [31:0] wl, wr;
          rd_ = (cfg == 2) ? 7 : 10;
          ra  = (cfg == 1) ? 7 : 11;
          rb  = 12;
          wl = mk(lk, ld_, la, lb);
          wr = mk(rk, rd_, ra, rb);
          lw = wr_of(lk, lwfp);
          rw = wr_of(rk, rwfp);
          raw = lw && rd_of(rk, lwfp, ld_, ra, rb);          // R4
          waw = lw && rw && lwfp == rwfp && ld_ == rd_;      // R5
          pair = (lk != K_FPA) && (rk == K_FPA) && !raw && !waw; // R1
          hz = (lk == K_ILD || lk == K_FLD) && rd_of(rk, lk == K_FLD, ld_, ra, rb); // R6
          el = '{0, 0, 0, 0}; er = '{0, 0, 0, 0};
          el[0] = 1;
          if (pair) er[0] = 1;
          else if (hz) er[2] = 1;      // R3 with R6 hold
          else er[1] = 1;              // R3
          @(negedge clk); in_valid = 1'b1; in_pkt = {wl, wr};
          @(posedge clk); #1; in_valid = 1'b0;
          chk("R9 stall on split pair", fetch_stall, !pair);
          watch_seq("R1 R2 R3 R4 R5 sweep", el, er, wl, wr);
        end

    // Sweep 2: load followed by a consumer in the next packet (R6)
    for (int li = 0; li < 2; li++)
      for (int c = 0; c < 8; c++) begin
        int lk = li ? K_FLD : K_ILD;
        bit hz, el[4], er[4];
        logic [31:0] al, ar, bl, br;
        al = mk(lk, 5, 1, 2);     ar = mk(K_FPA, 20, 21, 22);
        bl = mk(c, 23, 5, 5);     br = mk(K_FPA, 26, 24, 25);
        hz = rd_of(c, lk == K_FLD, 5, 5, 5);
        el = '{0, 0, 0, 0}; er = '{0, 0, 0, 0};
        if (c != K_FPA) begin el[hz] = 1; er[hz] = 1; end
        else begin el[hz] = 1; er[hz + 1] = 1; end
        @(negedge clk); in_valid = 1'b1; in_pkt = {al, ar};
        @(posedge clk); #1;
        chk("R9 no stall for clean pair", fetch_stall, 0);
        @(negedge clk); in_pkt = {bl, br};
        @(posedge clk); #1; in_valid = 1'b0;
        chk("R6 load pair issued", {iss_l_v, iss_r_v}, 2'b11);
        chk("R6 stall on load use", fetch_stall, hz || (c == K_FPA));
        watch_seq("R6 load-use sweep", el, er, bl, br);
      end

    // R9: a packet offered during a stall is ignored
    begin
      logic [31:0] wl, wr;
      wl = mk(K_FPA, 1, 2, 3); wr = mk(K_ALU, 4, 5, 6);
      @(negedge clk); in_valid = 1'b1; in_pkt = {wl, wr};
      @(posedge clk); #1;
      chk("R9 stall raised", fetch_stall, 1);
      in_pkt = {mk(K_ALU, 9, 9, 9), mk(K_FPA, 9, 9, 9)};
      @(posedge clk); #1; in_valid = 1'b0;
      chk("R9 left issued alone", {iss_l_v, iss_r_v}, 2'b10);
      chk("R9 stall released", fetch_stall, 0);
      @(posedge clk); #1;
      chk("R9 held right issued", {iss_l_v, iss_r_v}, 2'b01);
      chk("R9 held right word", iss_r_w, wr);
      @(posedge clk); #1;
      chk("R9 offered packet ignored", {iss_l_v, iss_r_v}, 2'b00);
    end
    finish_run();
  end
endmodule